// File: doc/BRIEF.md
# Mode-Selected Performance Event Counters

This block watches a processor core through per-cycle event strobes and counts what it sees in three counters. One counter tracks elapsed clock cycles. Two event counters take their sources from a shared mode field, which picks them as a pair: data-dependency stall cycles with data-cache write-backs, executed instructions with instruction-TLB table walks, or data accesses alone. Software reads the counters and divides them to get figures such as the stall fraction, cycles per instruction or the TLB miss rate.

The data-access source is not a single strobe. Each cycle the memory stage reports how many accesses the current instruction makes: one per register for a block transfer, two for a double-word load, one otherwise. The counter adds that amount in one step. All three counters wrap at their width and leave a sticky overflow flag behind, and any flag can be routed to one interrupt line. A small register port with one write strobe and a combinational read gives access to control, status and the three counter values.

Top module: `perfmon_top`

## Requirements
- R1: With mode 0 (stall/write-back), event counter 0 adds one for each cycle `ev_dep_stall` is high and event counter 1 adds one for each cycle `ev_dc_wback` is high; the instruction, walk and data-access inputs have no effect.
- R2: With mode 1 (instruction TLB), event counter 0 adds one per cycle with `ev_inst_exec` high, and event counter 1 adds one per cycle with `ev_itlb_walk` high only while `itlb_enabled` is high; the stall, write-back and data-access inputs have no effect.
- R3: With mode 2 (data access), event counter 0 adds `dacc_count` (0 to 16) in each cycle `dacc_valid` is high, so a block transfer of N registers adds N and a double-word load adds 2; event counter 1 holds, and the other inputs have no effect.
- R4: With mode 3 (idle), neither event counter changes, whatever the inputs.
- R5: While the enable bit is set, the cycle counter adds one every clock.
- R6: While the enable bit is clear, none of the three counters changes.
- R7: Writing CTRL with bit 1 set zeroes both event counters, and with bit 2 set zeroes the cycle counter, on the clock edge that takes the write; the reset wins over any increment in that cycle, and both bits read back as 0.
- R8: A mode written to CTRL applies to events presented from the cycle after the write cycle; events in the write cycle use the old mode. A mode change leaves the counter values alone.
- R9: Every counter wraps modulo 2^32. A wrap sets that counter's flag in STATUS (bit 0 cycle, bit 1 event 0, bit 2 event 1). The flag stays set through later counting until a 1 is written to that bit of STATUS.
- R10: `irq` is high exactly when some STATUS flag is set while its interrupt enable in CTRL (bit 8 cycle, bit 9 event 0, bit 10 event 1) is also set.
- R11: Register map: address 0 CTRL (bit 0 enable, bits 5:4 mode), 1 STATUS, 2 cycle counter, 3 event counter 0, 4 event counter 1. Writing a counter address loads the write data into that counter. After reset every register reads 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| ev_dep_stall | input | 1 | Pipeline stalled on a data dependency this cycle |
| ev_dc_wback | input | 1 | Data cache emits a write-back this cycle |
| ev_inst_exec | input | 1 | An instruction executed this cycle |
| ev_itlb_walk | input | 1 | Instruction TLB starts a table walk this cycle |
| itlb_enabled | input | 1 | Instruction TLB is switched on |
| dacc_valid | input | 1 | `dacc_count` is valid this cycle |
| dacc_count | input | 5 | Number of data accesses made by the current instruction |
| irq | output | 1 | Overflow interrupt |

## Verification
The assertions assume that `dacc_count` never goes above 16 when `dacc_valid` is high. They also assume the strobes are plain one-cycle levels, sampled on each rising edge, with no hold-off between them. The stimulus keeps to both: every data-access count it drives lies between 0 and 16, and it changes every input on the falling edge only. The bench drives a register write and event strobes in the same cycle only in the mode-change case, where the order is the point of the test.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;

   typedef enum logic [1:0] {
      PM_STALL_WB = 2'd0,
      PM_ITLB     = 2'd1,
      PM_DATA     = 2'd2,
      PM_IDLE     = 2'd3
   } pm_mode_e;

   // counter slots
   localparam int NUM_CNT  = 3;
   localparam int SLOT_CYC = 0;
   localparam int SLOT_EV0 = 1;
   localparam int SLOT_EV1 = 2;

   // register addresses
   localparam int A_CTRL = 0;
   localparam int A_STAT = 1;
   localparam int A_CNT0 = 2;   // counters follow in slot order

   // CTRL fields
   localparam int C_EN       = 0;
   localparam int C_RST_EV   = 1;
   localparam int C_RST_CYC  = 2;
   localparam int C_MODE_LSB = 4;
   localparam int C_IRQ_LSB  = 8;
   localparam int C_TOP_BIT  = C_IRQ_LSB + NUM_CNT - 1;

endpackage

// File: rtl/perfmon_counter.sv
module perfmon_counter
   import perfmon_pkg::*;
#(
   parameter int CNT_W = 32,
   parameter int INC_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             ld,
   input  logic [CNT_W-1:0] ld_val,
   input  logic             cnt_en,
   input  logic [INC_W-1:0] inc,
   input  logic             flag_clr,
   output logic [CNT_W-1:0] value,
   output logic             flag
);

   localparam int PAD_W = CNT_W + 1 - INC_W;

   logic [CNT_W:0] sum;
   logic           wrap;

   initial begin : p_param_chk
      assert (INC_W >= 1 && INC_W < CNT_W)
         else $error("perfmon_counter: INC_W must lie in 1..CNT_W-1");
   end

   assign sum  = {1'b0, value} + {{PAD_W{1'b0}}, inc};
   assign wrap = cnt_en && !clr && !ld && sum[CNT_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value <= '0;
      end else if (clr) begin
         value <= '0;
      end else if (ld) begin
         value <= ld_val;
      end else if (cnt_en) begin
         value <= sum[CNT_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0;
      end else if (wrap) begin
         flag <= 1'b1;
      end else if (flag_clr) begin
         flag <= 1'b0;
      end
   end

   AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (value == '0)) else $error("clear did not zero counter"); // R7

   AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_en && !clr && !ld) |=> $stable(value)) else $error("counter moved while off"); // R6

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !flag_clr) |=> flag) else $error("flag dropped without clear"); // R9

   AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (ld && !clr) |=> (value == $past(ld_val))) else $error("load lost"); // R11

endmodule

// File: rtl/perfmon_evsel.sv
module perfmon_evsel
   import perfmon_pkg::*;
#(
   parameter int INC_W = 5
) (
   input  pm_mode_e         mode,
   input  logic             dep_stall,
   input  logic             dc_wback,
   input  logic             inst_exec,
   input  logic             itlb_walk,
   input  logic             itlb_on,
   input  logic             dacc_valid,
   input  logic [INC_W-1:0] dacc_count,
   output logic [INC_W-1:0] inc_ev0,
   output logic [INC_W-1:0] inc_ev1
);

   localparam logic [INC_W-1:0] ONE  = INC_W'(1);
   localparam logic [INC_W-1:0] NONE = '0;

   always_comb begin
      inc_ev0 = NONE;
      inc_ev1 = NONE;
      unique case (mode)
         PM_STALL_WB: begin
            if (dep_stall) inc_ev0 = ONE;
            if (dc_wback)  inc_ev1 = ONE;
         end
         PM_ITLB: begin
            if (inst_exec)             inc_ev0 = ONE;
            if (itlb_walk && itlb_on)  inc_ev1 = ONE;
         end
         PM_DATA: begin
            if (dacc_valid) inc_ev0 = dacc_count;
         end
         default: begin
            inc_ev0 = NONE;
            inc_ev1 = NONE;
         end
      endcase
   end

endmodule

// File: rtl/perfmon_regs.sv
module perfmon_regs
   import perfmon_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 3
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr,
   input  logic [ADDR_W-1:0]               addr,
   input  logic [DATA_W-1:0]               wdata,
   output logic [DATA_W-1:0]               rdata,
   input  logic [NUM_CNT-1:0][CNT_W-1:0]   cnt_val,
   input  logic [NUM_CNT-1:0]              flags,
   output logic                            en,
   output pm_mode_e                        mode,
   output logic [NUM_CNT-1:0]              irq_en,
   output logic [NUM_CNT-1:0]              clr,
   output logic [NUM_CNT-1:0]              ld,
   output logic [CNT_W-1:0]                ld_val,
   output logic [NUM_CNT-1:0]              flag_clr
);

   logic sel_ctrl;
   logic sel_stat;
   logic wr_ctrl;

   assign sel_ctrl = (addr == ADDR_W'(A_CTRL));
   assign sel_stat = (addr == ADDR_W'(A_STAT));
   assign wr_ctrl  = wr && sel_ctrl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en     <= 1'b0;
         mode   <= PM_STALL_WB;
         irq_en <= '0;
      end else if (wr_ctrl) begin
         en     <= wdata[C_EN];
         mode   <= pm_mode_e'(wdata[C_MODE_LSB +: 2]);
         irq_en <= wdata[C_IRQ_LSB +: NUM_CNT];
      end
   end

   // reset pulses act at the edge that takes the write
   always_comb begin
      clr           = '0;
      clr[SLOT_CYC] = wr_ctrl && wdata[C_RST_CYC];
      clr[SLOT_EV0] = wr_ctrl && wdata[C_RST_EV];
      clr[SLOT_EV1] = wr_ctrl && wdata[C_RST_EV];
   end

   assign flag_clr = (wr && sel_stat) ? wdata[NUM_CNT-1:0] : '0;
   assign ld_val   = wdata[CNT_W-1:0];

   for (genvar i = 0; i < NUM_CNT; i++) begin : g_ld
      assign ld[i] = wr && (addr == ADDR_W'(A_CNT0 + i));
   end

   always_comb begin
      rdata = '0;
      if (sel_ctrl) begin
         rdata[C_EN]                    = en;
         rdata[C_MODE_LSB +: 2]         = mode;
         rdata[C_IRQ_LSB +: NUM_CNT]    = irq_en;
      end else if (sel_stat) begin
         rdata[NUM_CNT-1:0]             = flags;
      end else begin
         for (int i = 0; i < NUM_CNT; i++) begin
            if (addr == ADDR_W'(A_CNT0 + i)) rdata[CNT_W-1:0] = cnt_val[i];
         end
      end
   end

   AST_MODE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> (mode == pm_mode_e'($past(wdata[C_MODE_LSB +: 2]))))
      else $error("mode write lost"); // R8

endmodule

// File: rtl/perfmon_top.sv
module perfmon_top
   import perfmon_pkg::*;
#(
   parameter int CNT_W    = 32,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 3,
   parameter int DACC_W   = 5,
   parameter int DACC_MAX = 16,
   parameter bit IRQ_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              ev_dep_stall,
   input  logic              ev_dc_wback,
   input  logic              ev_inst_exec,
   input  logic              ev_itlb_walk,
   input  logic              itlb_enabled,
   input  logic              dacc_valid,
   input  logic [DACC_W-1:0] dacc_count,
   output logic              irq
);

   localparam int INC_W = DACC_W;

   initial begin : p_param_chk
      assert (DATA_W >= CNT_W)       else $error("perfmon_top: DATA_W below CNT_W");
      assert (DATA_W > C_TOP_BIT)    else $error("perfmon_top: DATA_W too narrow for CTRL");
      assert ((1 << ADDR_W) >= A_CNT0 + NUM_CNT)
         else $error("perfmon_top: ADDR_W too narrow for the map");
      assert (DACC_MAX < (1 << DACC_W)) else $error("perfmon_top: DACC_MAX needs wider DACC_W");
      assert (CNT_W > DACC_W)        else $error("perfmon_top: CNT_W must exceed DACC_W");
   end

   logic                          en;
   pm_mode_e                      mode;
   logic [NUM_CNT-1:0]            irq_en;
   logic [NUM_CNT-1:0]            clr;
   logic [NUM_CNT-1:0]            ld;
   logic [CNT_W-1:0]              ld_val;
   logic [NUM_CNT-1:0]            flag_clr;
   logic [NUM_CNT-1:0]            flags;
   logic [NUM_CNT-1:0][CNT_W-1:0] cnt_val;
   logic [NUM_CNT-1:0][INC_W-1:0] inc;
   logic [INC_W-1:0]              inc_ev0;
   logic [INC_W-1:0]              inc_ev1;
   logic                          irq_any;

   perfmon_regs #(
      .CNT_W  (CNT_W),
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (reg_wr),
      .addr     (reg_addr),
      .wdata    (reg_wdata),
      .rdata    (reg_rdata),
      .cnt_val  (cnt_val),
      .flags    (flags),
      .en       (en),
      .mode     (mode),
      .irq_en   (irq_en),
      .clr      (clr),
      .ld       (ld),
      .ld_val   (ld_val),
      .flag_clr (flag_clr)
   );

   perfmon_evsel #(
      .INC_W (INC_W)
   ) u_evsel (
      .mode       (mode),
      .dep_stall  (ev_dep_stall),
      .dc_wback   (ev_dc_wback),
      .inst_exec  (ev_inst_exec),
      .itlb_walk  (ev_itlb_walk),
      .itlb_on    (itlb_enabled),
      .dacc_valid (dacc_valid),
      .dacc_count (dacc_count),
      .inc_ev0    (inc_ev0),
      .inc_ev1    (inc_ev1)
   );

   assign inc[SLOT_CYC] = INC_W'(1);
   assign inc[SLOT_EV0] = inc_ev0;
   assign inc[SLOT_EV1] = inc_ev1;

   for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
      perfmon_counter #(
         .CNT_W (CNT_W),
         .INC_W (INC_W)
      ) u_cnt (
         .clk      (clk),
         .rst_n    (rst_n),
         .clr      (clr[i]),
         .ld       (ld[i]),
         .ld_val   (ld_val),
         .cnt_en   (en),
         .inc      (inc[i]),
         .flag_clr (flag_clr[i]),
         .value    (cnt_val[i]),
         .flag     (flags[i])
      );
   end

   assign irq_any = |(flags & irq_en);

   if (IRQ_REG) begin : g_irq_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= irq_any;
      end
   end else begin : g_irq_comb
      assign irq = irq_any;
   end

   AST_DACC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      dacc_valid |-> (dacc_count <= DACC_W'(DACC_MAX))) else $error("access count out of range"); // R3

   AST_ITLB_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == PM_ITLB && !itlb_enabled && !clr[SLOT_EV1] && !ld[SLOT_EV1])
      |=> $stable(cnt_val[SLOT_EV1])) else $error("walk counted with TLB off"); // R2

   AST_IDLE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == PM_IDLE && !clr[SLOT_EV0] && !ld[SLOT_EV0] && !clr[SLOT_EV1] && !ld[SLOT_EV1])
      |=> ($stable(cnt_val[SLOT_EV0]) && $stable(cnt_val[SLOT_EV1])))
      else $error("event counted in idle mode"); // R4

   AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !clr[SLOT_CYC] && !ld[SLOT_CYC])
      |=> (cnt_val[SLOT_CYC] == $past(cnt_val[SLOT_CYC]) + CNT_W'(1)))
      else $error("cycle counter missed a step"); // R5

endmodule

// File: tb/perfmon_top_bench.sv
module perfmon_top_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        ev_dep_stall = 1'b0;
   logic        ev_dc_wback = 1'b0;
   logic        ev_inst_exec = 1'b0;
   logic        ev_itlb_walk = 1'b0;
   logic        itlb_enabled = 1'b0;
   logic        dacc_valid = 1'b0;
   logic [4:0]  dacc_count = '0;
   logic        irq;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   perfmon_top u_perfmon_top (
      .clk          (clk),
      .rst_n        (rst_n),
      .reg_wr       (reg_wr),
      .reg_addr     (reg_addr),
      .reg_wdata    (reg_wdata),
      .reg_rdata    (reg_rdata),
      .ev_dep_stall (ev_dep_stall),
      .ev_dc_wback  (ev_dc_wback),
      .ev_inst_exec (ev_inst_exec),
      .ev_itlb_walk (ev_itlb_walk),
      .itlb_enabled (itlb_enabled),
      .dacc_valid   (dacc_valid),
      .dacc_count   (dacc_count),
      .irq          (irq)
   );

   localparam logic [2:0] AD_CTRL = 3'd0, AD_STAT = 3'd1, AD_CYC = 3'd2,
                          AD_EV0 = 3'd3, AD_EV1 = 3'd4;
   localparam logic [31:0] EN = 32'h1, RST_EV = 32'h2, RST_CYC = 32'h4;

   // {mode[23:22], stall, wback, exec, walk, tlb_on, dvalid, dcount[15:11], exp0[10:5], exp1[4:0]}
   localparam int NV = 12;
   localparam logic [23:0] VEC [NV] = '{
      {2'd0, 1'b1,1'b1,1'b0,1'b0,1'b0, 1'b0,5'd0,  6'd1,  5'd1},
      {2'd0, 1'b0,1'b0,1'b1,1'b1,1'b1, 1'b1,5'd4,  6'd0,  5'd0},
      {2'd1, 1'b0,1'b0,1'b1,1'b1,1'b1, 1'b0,5'd0,  6'd1,  5'd1},
      {2'd1, 1'b0,1'b0,1'b1,1'b1,1'b0, 1'b0,5'd0,  6'd1,  5'd0},
      {2'd1, 1'b1,1'b1,1'b0,1'b0,1'b1, 1'b1,5'd3,  6'd0,  5'd0},
      {2'd1, 1'b0,1'b0,1'b0,1'b1,1'b1, 1'b0,5'd0,  6'd0,  5'd1},
      {2'd2, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,5'd1,  6'd1,  5'd0},
      {2'd2, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,5'd2,  6'd2,  5'd0},
      {2'd2, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,5'd16, 6'd16, 5'd0},
      {2'd2, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,5'd7,  6'd0,  5'd0},
      {2'd2, 1'b1,1'b1,1'b1,1'b1,1'b1, 1'b0,5'd0,  6'd0,  5'd0},
      {2'd3, 1'b1,1'b1,1'b1,1'b1,1'b1, 1'b1,5'd9,  6'd0,  5'd0}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      reg_wr   = 1'b0;
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic stim(input logic [23:0] v);
      ev_dep_stall = v[21]; ev_dc_wback = v[20]; ev_inst_exec = v[19];
      ev_itlb_walk = v[18]; itlb_enabled = v[17]; dacc_valid = v[16];
      dacc_count   = v[15:11];
   endtask

   task automatic quiet();
      stim(24'h0);
   endtask

   task automatic pulse(input logic [23:0] v, input int n);
      stim(v);
      repeat (n) @(negedge clk);
      quiet();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=expired expected=finished");
      finish_run();
   end

   initial begin : main
      logic [31:0] d;
      string tg;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11: reset state
      for (int a = 0; a < 5; a++) begin
         rd(3'(a), d);
         chk("R11 reset value", d, 32'h0);
      end
      chk("R11 irq after reset", {31'h0, irq}, 32'h0);

      // R1..R4: table walk, one stimulus cycle per vector
      for (int i = 0; i < NV; i++) begin
         logic [31:0] m;
         m = {30'h0, VEC[i][23:22]};
         case (VEC[i][23:22])
            2'd0: tg = "R1";
            2'd1: tg = "R2";
            2'd2: tg = "R3";
            default: tg = "R4";
         endcase
         wr(AD_CTRL, EN | RST_EV | (m << 4));
         pulse(VEC[i], 1);
         rd(AD_EV0, d);
         chk($sformatf("%s vec%0d ev0", tg, i), d, {26'h0, VEC[i][10:5]});
         rd(AD_EV1, d);
         chk($sformatf("%s vec%0d ev1", tg, i), d, {27'h0, VEC[i][4:0]});
      end

      // R7: reset bits read back 0, cycle reset wins over counting
      wr(AD_CTRL, EN | RST_CYC | RST_EV);
      rd(AD_CTRL, d);
      chk("R7 reset bits read 0", d, 32'h1);
      rd(AD_CYC, d);
      chk("R7 cycle cleared", d, 32'h0);

      // R5: ten cycles later
      repeat (10) @(negedge clk);
      rd(AD_CYC, d);
      chk("R5 cycle count", d, 32'd10);

      // R6: enable clear freezes everything
      wr(AD_CTRL, RST_EV | RST_CYC);
      pulse({2'd0, 1'b1,1'b1,1'b0,1'b0,1'b0, 1'b0,5'd0, 6'd0,5'd0}, 3);
      rd(AD_EV0, d);  chk("R6 ev0 frozen", d, 32'h0);
      rd(AD_EV1, d);  chk("R6 ev1 frozen", d, 32'h0);
      rd(AD_CYC, d);  chk("R6 cycle frozen", d, 32'h0);

      // R8: mode change timing, counters kept
      wr(AD_CTRL, EN | RST_EV);
      pulse({2'd0, 1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0,5'd0, 6'd0,5'd0}, 3);
      reg_wr = 1'b1; reg_addr = AD_CTRL; reg_wdata = EN | (32'd1 << 4);
      ev_dep_stall = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
      @(negedge clk);
      quiet();
      rd(AD_EV0, d);  chk("R8 old mode in write cycle only", d, 32'd4);
      rd(AD_CTRL, d); chk("R8 mode readback", d, 32'h11);

      // R9: wrap of event counter 0 in stall mode
      wr(AD_CTRL, EN | RST_EV);
      wr(AD_EV0, 32'hFFFF_FFFE);
      rd(AD_EV0, d);  chk("R11 counter load", d, 32'hFFFF_FFFE);
      pulse({2'd0, 1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0,5'd0, 6'd0,5'd0}, 1);
      rd(AD_EV0, d);  chk("R9 before wrap", d, 32'hFFFF_FFFF);
      rd(AD_STAT, d); chk("R9 no flag yet", d, 32'h0);
      pulse({2'd0, 1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0,5'd0, 6'd0,5'd0}, 1);
      rd(AD_EV0, d);  chk("R9 wrapped", d, 32'h0);
      rd(AD_STAT, d); chk("R9 flag set", d, 32'h2);
      pulse({2'd0, 1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0,5'd0, 6'd0,5'd0}, 1);
      rd(AD_STAT, d); chk("R9 flag sticky", d, 32'h2);
      chk("R10 irq masked", {31'h0, irq}, 32'h0);

      // R10: interrupt routing
      wr(AD_CTRL, EN | (32'h1 << 10));
      rd(AD_STAT, d);
      chk("R10 other enable only", {31'h0, irq}, 32'h0);
      wr(AD_CTRL, EN | (32'h1 << 9));
      rd(AD_STAT, d);
      chk("R10 irq raised", {31'h0, irq}, 32'h1);
      wr(AD_STAT, 32'h2);
      rd(AD_STAT, d); chk("R9 flag cleared", d, 32'h0);
      chk("R10 irq dropped", {31'h0, irq}, 32'h0);

      // R3 + R9: multi-access wrap in data mode
      wr(AD_CTRL, EN | (32'd2 << 4));
      wr(AD_EV0, 32'hFFFF_FFF5);
      pulse({2'd2, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,5'd16, 6'd0,5'd0}, 1);
      rd(AD_EV0, d);  chk("R3 sixteen-access wrap", d, 32'h5);
      rd(AD_STAT, d); chk("R9 data-mode flag", d, 32'h2);

      finish_run();
   end

endmodule